// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the loudness contour of a single FM synthesis operator. The contour is kept as a 10-bit attenuation value. A value of 0 is full volume and 0x3FF is silence. The block walks through four phases: attack, decay, sustain and release. A key-on input starts the attack phase and a key-off moves the block to release. The speed of each phase comes from a rate register, raised by a key-scale term taken from the note's key code.

New levels are computed only on a per-sample strobe. On that strobe the block also takes a global envelope timer state: a shift value and two low timer bits. Together these set how often a step happens, and how large it is, for a given effective rate. In attack the level falls along an exponential curve. In the other three phases it rises by a power of two. The output adds the total-level offset to the level and saturates the result.

Top module: `fm_env_gen`

## Requirements
- R1: While reset is held and after it is released, the block is in release at level 0x3FF, so `atten_o` reads 0x3FF.
- R2: On a strobe where `key_i` is high and was low at the previous strobe, the block enters attack. If the effective rate shifted right by one equals 31 (rate 62 or 63), the level becomes 0 on that strobe.
- R3: In attack with step `inc` > 0 (and the rate not maximal), the level L becomes L − ceil((L+1)·2^inc / 32). Attack passes to decay on the first strobe that finds the level at 0.
- R4: In decay, sustain and release, a step `inc` > 0 adds 2^(inc−1) to the level. Decay passes to sustain, with no step, on the strobe where level/32 equals the sustain level. A sustain level of 15 counts as 31.
- R5: Key-off moves the block to release on the strobe that samples it. In release the register rate is `rel_rate_i`·2+1.
- R6: Outside attack, when a strobe finds the level at 0x3F0 or above and there is no key-on edge, the level becomes 0x3FF and the phase becomes release.
- R7: `atten_o` equals level + 8·`tl_i`, capped at 0x3FF.
- R8: On cycles without `tick_i` the level and phase hold, and `key_i` is not sampled.
- R9: Effective rate = min(63, 2·register rate + (`kcode_i` >> (3 − `ksc_i`))). The attack register is used on a key-on edge; otherwise the register of the current phase is used.
- R10: For an effective rate below 48, let s = (rate >> 2) + `shift_i`. A step exists only when bits 3 and 2 of s are both 1. If s[1:0] is 0 the step is 1. Otherwise the step is (s[0] AND rate[1]) OR (s[1] AND rate[0]).
- R11: A register rate of 0 gives a step of 0.
- R12: For an effective rate of 48 or more, the step is min(4, h + (rate >> 2) − 11). Here h is 1 when: rate[1:0]=1 and `tmr_lo_i`=0; rate[1:0]=2 and `tmr_lo_i` is even; or rate[1:0]=3 and `tmr_lo_i`≠3. Otherwise h is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Per-sample update strobe |
| key_i | input | 1 | Key-on level |
| atk_rate_i | input | 5 | Attack rate |
| dec_rate_i | input | 5 | Decay rate |
| sus_rate_i | input | 5 | Sustain-phase rate |
| rel_rate_i | input | 4 | Release rate |
| sus_lvl_i | input | 4 | Sustain level (units of 32) |
| tl_i | input | 7 | Total level offset (units of 8) |
| ksc_i | input | 2 | Key-scale setting |
| kcode_i | input | 5 | Key code |
| shift_i | input | 4 | Global envelope timer shift value |
| tmr_lo_i | input | 2 | Global envelope timer low bits |
| atten_o | output | 10 | Final attenuation |

## Verification
The hardest case to reach from the ports is the decay-to-sustain hand-over at sustain level 15. The level has to climb to 992 in decay, and then creep in sustain into the forced-silence band at 0x3F0, all with the key still held. The stimulus reaches it in four steps: an instant attack, a fast decay rate, a slow sustain rate, and then several hundred strobes. The low-rate gating of R10 shows only at particular shift values, so the bench sweeps `shift_i` over all sixteen values during a slow attack. It also cycles `tmr_lo_i` during a fast attack to cover every column of the high-rate pattern.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;
  localparam int LVL_W   = 10;
  localparam int RATE_W  = 5;
  localparam int REL_W   = RATE_W - 1;
  localparam int EFF_W   = RATE_W + 1;
  localparam int INC_W   = 3;
  localparam int SHIFT_W = 4;
  localparam int TLO_W   = 2;
  localparam int SL_W    = 4;
  localparam int TL_W    = 7;
  localparam int KC_W    = 5;
  localparam int KS_W    = 2;
  localparam int EFF_MAX = (1 << EFF_W) - 1;
  localparam int HI_BASE = 48;
  localparam int INC_CAP = 4;

  typedef enum logic [1:0] {
    ST_ATT = 2'd0,
    ST_DEC = 2'd1,
    ST_SUS = 2'd2,
    ST_REL = 2'd3
  } env_state_e;
endpackage

// File: rtl/fm_env_rate.sv
module fm_env_rate
  import fm_env_pkg::*;
(
  input  env_state_e              st_i,
  input  logic                    kon_edge_i,
  input  logic [RATE_W-1:0]       atk_rate_i,
  input  logic [RATE_W-1:0]       dec_rate_i,
  input  logic [RATE_W-1:0]       sus_rate_i,
  input  logic [REL_W-1:0]        rel_rate_i,
  input  logic [KS_W-1:0]         ksc_i,
  input  logic [KC_W-1:0]         kcode_i,
  output logic [EFF_W-1:0]        eff_rate_o,
  output logic                    reg_nz_o
);
  localparam int SUM_W = EFF_W + 1;

  env_state_e          sel;
  logic [RATE_W-1:0]   reg_rate;
  logic [KC_W-1:0]     ksv;
  logic [SUM_W-1:0]    raw;

  always_comb begin
    sel = kon_edge_i ? ST_ATT : st_i;
    unique case (sel)
      ST_ATT:  reg_rate = atk_rate_i;
      ST_DEC:  reg_rate = dec_rate_i;
      ST_SUS:  reg_rate = sus_rate_i;
      default: reg_rate = {rel_rate_i, 1'b1};
    endcase
    ksv = kcode_i >> (ksc_i ^ {KS_W{1'b1}});
    raw = {1'b0, reg_rate, 1'b0} + SUM_W'(ksv);
    eff_rate_o = (raw > SUM_W'(EFF_MAX)) ? EFF_W'(EFF_MAX) : raw[EFF_W-1:0];
    reg_nz_o = |reg_rate;
  end
endmodule

// File: rtl/fm_env_step.sv
module fm_env_step
  import fm_env_pkg::*;
(
  input  logic [EFF_W-1:0]   eff_rate_i,
  input  logic               reg_nz_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [TLO_W-1:0]   tmr_lo_i,
  output logic [INC_W-1:0]   inc_o,
  output logic               rate_max_o
);
  localparam int HI_W = EFF_W - 2;
  localparam int S_W  = SHIFT_W + 1;

  logic [S_W-1:0]  s;
  logic            hi_bit;
  logic [HI_W:0]   hi_sum;
  logic [3:0]      row_hit;

  // high-rate pattern, one row per rate[1:0]
  assign row_hit[0] = 1'b0;
  assign row_hit[1] = (tmr_lo_i == 2'd0);
  assign row_hit[2] = ~tmr_lo_i[0];
  assign row_hit[3] = (tmr_lo_i != 2'd3);

  always_comb begin
    s      = S_W'(eff_rate_i[EFF_W-1:2]) + S_W'(shift_i);
    hi_bit = row_hit[eff_rate_i[1:0]];
    hi_sum = (HI_W+1)'(hi_bit) + (HI_W+1)'(eff_rate_i[EFF_W-1:2]) - (HI_W+1)'(11);
    inc_o  = '0;
    if (reg_nz_i) begin
      if (eff_rate_i < EFF_W'(HI_BASE)) begin
        if (s[3:2] == 2'b11) begin
          if (s[1:0] == 2'b00) inc_o = INC_W'(1);
          else inc_o = INC_W'((s[0] & eff_rate_i[1]) | (s[1] & eff_rate_i[0]));
        end
      end else begin
        inc_o = (hi_sum > (HI_W+1)'(INC_CAP)) ? INC_W'(INC_CAP) : hi_sum[INC_W-1:0];
      end
    end
    rate_max_o = &eff_rate_i[EFF_W-1:1];
  end
endmodule

// File: rtl/fm_env_core.sv
module fm_env_core
  import fm_env_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              key_i,
  input  logic              kon_edge_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              rate_max_i,
  input  logic [SL_W-1:0]   sus_lvl_i,
  output logic [LVL_W-1:0]  lvl_o,
  output env_state_e        st_o,
  output logic              kon_q_o
);
  localparam int SW = 16;

  logic [LVL_W-1:0]   lvl_q, nxt_l, add, lin_d;
  env_state_e         st_q, nxt_s;
  logic               kon_q, off;
  logic [SL_W:0]      sl_x;
  logic signed [SW-1:0] inv_s, atk_s;

  always_comb begin
    off   = &lvl_q[LVL_W-1:4];
    sl_x  = (&sus_lvl_i) ? '1 : {1'b0, sus_lvl_i};
    inv_s = $signed({{(SW-LVL_W){1'b1}}, ~lvl_q});
    atk_s = (inv_s <<< inc_i) >>> 5;
    lin_d = (inc_i == '0) ? '0 : (LVL_W'(1) << (inc_i - INC_W'(1)));
    nxt_l = lvl_q;
    nxt_s = st_q;
    add   = '0;
    if (kon_edge_i) begin
      nxt_s = ST_ATT;
      if (rate_max_i) nxt_l = '0;
      else if (st_q == ST_ATT && lvl_q != '0 && inc_i != '0) add = atk_s[LVL_W-1:0];
    end else begin
      unique case (st_q)
        ST_ATT: begin
          if (lvl_q == '0) nxt_s = ST_DEC;
          else if (inc_i != '0 && !rate_max_i) add = atk_s[LVL_W-1:0];
        end
        ST_DEC: begin
          if (!off && lvl_q[LVL_W-1:5] == sl_x) nxt_s = ST_SUS;
          else if (!off) add = lin_d;
        end
        default: if (!off) add = lin_d;
      endcase
      if (!key_i) nxt_s = ST_REL;
    end
    // silence band outside attack
    if (!kon_edge_i && st_q != ST_ATT && off) begin
      nxt_s = ST_REL;
      nxt_l = '1;
    end
    nxt_l = nxt_l + add;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '1;
      st_q  <= ST_REL;
      kon_q <= 1'b0;
    end else if (tick_i) begin
      lvl_q <= nxt_l;
      st_q  <= nxt_s;
      kon_q <= key_i;
    end
  end

  assign lvl_o   = lvl_q;
  assign st_o    = st_q;
  assign kon_q_o = kon_q;
endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen
  import fm_env_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               key_i,
  input  logic [RATE_W-1:0]  atk_rate_i,
  input  logic [RATE_W-1:0]  dec_rate_i,
  input  logic [RATE_W-1:0]  sus_rate_i,
  input  logic [REL_W-1:0]   rel_rate_i,
  input  logic [SL_W-1:0]    sus_lvl_i,
  input  logic [TL_W-1:0]    tl_i,
  input  logic [KS_W-1:0]    ksc_i,
  input  logic [KC_W-1:0]    kcode_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [TLO_W-1:0]   tmr_lo_i,
  output logic [LVL_W-1:0]   atten_o
);
  localparam int TLS = 3;

  logic [LVL_W-1:0] lvl_w;
  env_state_e       st_w;
  logic             kon_q_w, kon_edge_w, reg_nz_w, rate_max_w;
  logic [EFF_W-1:0] eff_rate_w;
  logic [INC_W-1:0] inc_w;
  logic [LVL_W:0]   full_w;

  assign kon_edge_w = key_i & ~kon_q_w;

  fm_env_rate u_rate (
    .st_i(st_w), .kon_edge_i(kon_edge_w),
    .atk_rate_i(atk_rate_i), .dec_rate_i(dec_rate_i),
    .sus_rate_i(sus_rate_i), .rel_rate_i(rel_rate_i),
    .ksc_i(ksc_i), .kcode_i(kcode_i),
    .eff_rate_o(eff_rate_w), .reg_nz_o(reg_nz_w)
  );

  fm_env_step u_step (
    .eff_rate_i(eff_rate_w), .reg_nz_i(reg_nz_w),
    .shift_i(shift_i), .tmr_lo_i(tmr_lo_i),
    .inc_o(inc_w), .rate_max_o(rate_max_w)
  );

  fm_env_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .key_i(key_i),
    .kon_edge_i(kon_edge_w), .inc_i(inc_w), .rate_max_i(rate_max_w),
    .sus_lvl_i(sus_lvl_i), .lvl_o(lvl_w), .st_o(st_w), .kon_q_o(kon_q_w)
  );

  assign full_w  = {1'b0, lvl_w} + {1'b0, tl_i, {TLS{1'b0}}};
  assign atten_o = full_w[LVL_W] ? '1 : full_w[LVL_W-1:0];
endmodule

// File: rtl/fm_env_gen_chk.sv
module fm_env_gen_chk
  import fm_env_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             key_i,
  input logic [LVL_W-1:0] atten_o,
  input logic [LVL_W-1:0] lvl,
  input env_state_e       st,
  input logic             kon_q,
  input logic [EFF_W-1:0] eff_rate
);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(lvl) && $stable(st) && $stable(kon_q)));

  p_instant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && key_i && !kon_q && eff_rate >= EFF_W'(62)) |=> (lvl == '0 && st == ST_ATT));

  p_attack_falls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && st == ST_ATT) |=> (lvl <= $past(lvl)));

  p_decay_rises_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && st == ST_DEC && key_i) |=> (lvl >= $past(lvl)));

  p_keyoff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !key_i) |=> (st == ST_REL));

  p_release_rises_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && st == ST_REL && !key_i) |=> (lvl >= $past(lvl)));

  p_silence_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(key_i && !kon_q) && st != ST_ATT && (&lvl[LVL_W-1:4]))
      |=> (lvl == '1 && st == ST_REL));

  p_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    atten_o >= lvl);
endmodule

bind fm_env_gen fm_env_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .key_i(key_i),
  .atten_o(atten_o), .lvl(lvl_w), .st(st_w), .kon_q(kon_q_w),
  .eff_rate(eff_rate_w)
);

// File: tb/fm_env_gen_test.sv
module fm_env_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       key_i = 1'b0;
  logic [4:0] atk_rate_i = '0, dec_rate_i = '0, sus_rate_i = '0;
  logic [3:0] rel_rate_i = '0, sus_lvl_i = '0;
  logic [6:0] tl_i = '0;
  logic [1:0] ksc_i = '0, tmr_lo_i = '0;
  logic [4:0] kcode_i = '0;
  logic [3:0] shift_i = '0;
  logic [9:0] atten_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int m_lvl = 1023, m_st = 3, m_kon = 0;

  always #4 clk_i = ~clk_i;

  fm_env_gen uut (
    .clk_i, .rst_ni, .tick_i, .key_i, .atk_rate_i, .dec_rate_i, .sus_rate_i,
    .rel_rate_i, .sus_lvl_i, .tl_i, .ksc_i, .kcode_i, .shift_i, .tmr_lo_i, .atten_o
  );

  function automatic int eff_of(int r);
    int v = 2 * r + (int'(kcode_i) >> (3 - int'(ksc_i)));
    return (v > 63) ? 63 : v;
  endfunction

  function automatic int step_of(int r, int e);
    int s, hb, v;
    if (r == 0) return 0;
    if (e < 48) begin
      s = (e >> 2) + int'(shift_i);
      if (((s >> 2) & 3) != 3) return 0;
      if ((s % 4) == 0) return 1;
      return (((s & 1) != 0 && (e & 2) != 0) || ((s & 2) != 0 && (e & 1) != 0)) ? 1 : 0;
    end
    case (e % 4)
      1: hb = (tmr_lo_i == 0) ? 1 : 0;
      2: hb = (tmr_lo_i % 2 == 0) ? 1 : 0;
      3: hb = (tmr_lo_i != 3) ? 1 : 0;
      default: hb = 0;
    endcase
    v = hb + e / 4 - 11;
    return (v > 4) ? 4 : v;
  endfunction

  function automatic int atk_next(int l, int inc);
    return l - ((((l + 1) << inc) + 31) / 32);
  endfunction

  task automatic model();
    int ev, sel, r, e, inc, slx, nl, ns;
    bit rmax, off;
    ev  = (key_i && !m_kon) ? 1 : 0;
    sel = ev ? 0 : m_st;
    case (sel)
      0: r = atk_rate_i;
      1: r = dec_rate_i;
      2: r = sus_rate_i;
      default: r = rel_rate_i * 2 + 1;
    endcase
    e = eff_of(r); inc = step_of(r, e);
    rmax = (e >= 62); off = (m_lvl >= 1008);
    nl = m_lvl; ns = m_st;
    if (ev) begin
      ns = 0;
      if (rmax) nl = 0;
      else if (m_st == 0 && m_lvl != 0 && inc != 0) nl = atk_next(m_lvl, inc);
    end else begin
      case (m_st)
        0: if (m_lvl == 0) ns = 1; else if (inc != 0 && !rmax) nl = atk_next(m_lvl, inc);
        1: begin
          slx = (sus_lvl_i == 15) ? 31 : sus_lvl_i;
          if (!off && m_lvl / 32 == slx) ns = 2;
          else if (!off && inc != 0) nl = m_lvl + (1 << (inc - 1));
        end
        default: if (!off && inc != 0) nl = m_lvl + (1 << (inc - 1));
      endcase
      if (!key_i) ns = 3;
    end
    if (!ev && m_st != 0 && off) begin ns = 3; nl = 1023; end
    m_lvl = nl % 1024; m_st = ns; m_kon = key_i;
  endtask

  function automatic int exp_att();
    int v = m_lvl + 8 * int'(tl_i);
    return (v > 1023) ? 1023 : v;
  endfunction

  task automatic chk(int exp, string tag);
    n_chk++;
    if (int'(atten_o) != exp) begin
      n_err++;
      $display("FAIL %s: atten_o=%0h expected %0h", tag, atten_o, exp);
    end
  endtask

  task automatic tick_n(int n, string tag);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk_i);
      model();
      chk(exp_att(), tag);
    end
    tick_i = 1'b0;
  endtask

  task automatic go_silent();
    key_i = 0; rel_rate_i = 4'd15; ksc_i = 0; kcode_i = 0;
    for (int i = 0; i < 300; i++) begin
      if (m_lvl == 1023 && m_st == 3 && m_kon == 0) break;
      tick_n(1, "R6");
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(1023, "R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(1023, "R1");
    tick_n(3, "R1");
  endtask

  task automatic t_tick_gate();
    tl_i = 7'd5; atk_rate_i = 5'd31; key_i = 1;
    for (int i = 0; i < 4; i++) begin @(negedge clk_i); chk(1023, "R8"); end
    tick_n(1, "R2");
    chk(40, "R2");
    key_i = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk_i); chk(40, "R8"); end
    key_i = 1;
  endtask

  task automatic t_decay_sustain();
    dec_rate_i = 5'd28; sus_lvl_i = 4'd2; sus_rate_i = 5'd0; shift_i = 0; tmr_lo_i = 0;
    tick_n(40, "R4");
    chk(64 + 40, "R4");
    tick_n(10, "R11");
    chk(64 + 40, "R11");
  endtask

  task automatic t_release();
    key_i = 0; rel_rate_i = 4'd4; shift_i = 4'd8;
    tick_n(30, "R5");
    chk(93 + 40, "R5");
    shift_i = 0;
    go_silent();
    chk(1023, "R6");
  endtask

  task automatic t_sl15();
    tl_i = 0; atk_rate_i = 5'd31; key_i = 1;
    tick_n(1, "R2");
    dec_rate_i = 5'd28; sus_lvl_i = 4'd15; sus_rate_i = 5'd24;
    tick_n(280, "R4");
    chk(1023, "R6");
  endtask

  task automatic t_attack();
    key_i = 0; go_silent();
    atk_rate_i = 5'd29; dec_rate_i = 0; sus_lvl_i = 4'd2; key_i = 1;
    for (int i = 0; i < 60; i++) begin
      tmr_lo_i = 2'(i % 4);
      tick_n(1, "R12");
    end
    chk(0, "R3");
    tmr_lo_i = 0;
  endtask

  task automatic t_low_rate();
    go_silent();
    atk_rate_i = 5'd10; key_i = 1;
    for (int i = 0; i < 64; i++) begin
      shift_i = 4'(i % 16);
      tick_n(1, "R10");
    end
    shift_i = 0;
  endtask

  task automatic t_key_scale();
    go_silent();
    atk_rate_i = 5'd20; kcode_i = 5'd31; ksc_i = 2'd3; key_i = 1;
    tick_n(1, "R9");
    chk(0, "R9");
    go_silent();
    atk_rate_i = 5'd20; kcode_i = 5'd31; ksc_i = 2'd0; key_i = 1;
    tick_n(3, "R9");
    chk(1023, "R9");
  endtask

  task automatic t_saturate();
    go_silent();
    atk_rate_i = 5'd31; tl_i = 7'd127; key_i = 1;
    tick_n(1, "R7");
    chk(1016, "R7");
    dec_rate_i = 5'd28; sus_lvl_i = 4'd15;
    tick_n(3, "R7");
    chk(1023, "R7");
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    t_tick_gate();
    t_decay_sustain();
    t_release();
    t_sl15();
    t_attack();
    t_low_rate();
    t_key_scale();
    t_saturate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule